// File: doc/BRIEF.md
# Wake-up Request Detector

This block watches a bus transceiver that is in a low-power state and decides when a wake-up request has arrived. A request can come from two sources. A local request is a change on the wake pin, in either direction, that stays at its new level for a programmable number of clock cycles. A remote request is the digitized bus-dominant indication staying asserted for a separately programmed number of cycles. Either request sets a sticky wake-up flag, but only while the low-power enable is high and the undervoltage block is low. A separate source flag records that the request was local.

The settled wake pin level drives a bias-control output. When it is high it selects the pull-up, and when it is low it selects the pull-down. The settled level changes only after the same filter that qualifies a local request has run out. The mode controller drives the flag clear and the source clear, and it also supplies the power-on flag, which stops the source flag from being set.

Top module: `wake_detect`

## Requirements
- R1: A wake pin level that differs from the settled level on WAKE_CYC consecutive rising clock edges is accepted at the last of those edges, for a rising change and for a falling change alike. When accepted, it sets wake_flag_o, provided the request is allowed.
- R2: A wake pin change that reverts before WAKE_CYC edges restarts the filter. It sets no flag and leaves bias_up_o unchanged.
- R3: bus_dom_i high on BUS_CYC consecutive edges sets wake_flag_o at the last of those edges. Shorter dominant pulses set nothing.
- R4: wake_flag_o is never set while lp_mode_i is low.
- R5: wake_flag_o is never set while uv_block_i is high.
- R6: flag_clr_i high clears wake_flag_o on the next edge and takes priority over a request on the same edge.
- R7: wake_src_o is set by an allowed local request, and only when pwon_i and flag_clr_i are low. A remote request never sets it.
- R8: src_clr_i high clears wake_src_o on the next edge. While wake_src_o is low and pwon_i is high, wake_src_o stays low.
- R9: bias_up_o equals the settled wake pin level. That level is captured on the first edge after reset, without raising a request, and is updated whenever a change is accepted.
- R10: During reset and just after it, wake_flag_o and wake_src_o are 0.
- R11: The bus filter saturates. Dominant held without a break produces a single request, and the filter re-arms only after bus_dom_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_pin_i | input | 1 | Synchronized local wake pin |
| bus_dom_i | input | 1 | Bus dominant indication (1 = dominant) |
| lp_mode_i | input | 1 | High while in a low-power mode; allows the flag to be set |
| uv_block_i | input | 1 | High during the undervoltage waiting period; blocks setting |
| flag_clr_i | input | 1 | Clears the wake-up flag (power-on, undervoltage, normal entry) |
| pwon_i | input | 1 | Power-on flag; while high the source flag cannot be set |
| src_clr_i | input | 1 | Clears the source flag (leaving normal mode) |
| wake_flag_o | output | 1 | Sticky wake-up flag |
| wake_src_o | output | 1 | 1 = wake-up came from the local pin |
| bias_up_o | output | 1 | 1 = pull-up, 0 = pull-down on the wake pin |

## Verification
A wrong settled level or a counter that restarts incorrectly shows up on bias_up_o, and on wake_flag_o, exactly WAKE_CYC edges after a pin change. The checks therefore sample one cycle before and one cycle at the expected acceptance edge. A bus filter that does not saturate shows up as a second flag set while dominant is held after a clear. Gating faults, such as setting outside the low-power mode, during the undervoltage block or while power-on is high, appear on the next edge as a flag or source bit that should have stayed low.

// File: rtl/wake_detect_pkg.sv
package wake_detect_pkg;
  typedef struct packed {
    logic loc;
    logic rem;
  } wake_req_t;
endpackage

// File: rtl/wake_pin_filter.sv
module wake_pin_filter #(
  parameter int unsigned WAKE_CYC = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic req_o,
  output logic level_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  logic          primed_q;
  logic          ref_q;
  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = primed_q && (pin_i != ref_q);
  assign req_o  = differ && (cnt_q == LAST);
  assign level_o = ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      ref_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (!primed_q) begin
      primed_q <= 1'b1;
      ref_q    <= pin_i;
      cnt_q    <= '0;
    end else if (req_o) begin
      ref_q <= pin_i;
      cnt_q <= '0;
    end else if (differ) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/wake_bus_filter.sv
module wake_bus_filter #(
  parameter int unsigned BUS_CYC = 219
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dom_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(BUS_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(BUS_CYC);
  localparam logic [CW-1:0] LAST = CW'(BUS_CYC - 1);

  logic [CW-1:0] cnt_q;

  // one event on the step into saturation
  assign req_o = dom_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!dom_i)           cnt_q <= '0;
    else if (cnt_q != FULL)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wake_flag_ctrl.sv
module wake_flag_ctrl
  import wake_detect_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wake_req_t req_i,
  input  logic      lp_mode_i,
  input  logic      uv_block_i,
  input  logic      flag_clr_i,
  input  logic      pwon_i,
  input  logic      src_clr_i,
  output logic      flag_o,
  output logic      src_o
);
  logic allow, set_any, set_src;
  logic flag_q, src_q;

  assign allow   = lp_mode_i && !uv_block_i;
  assign set_any = allow && (req_i.loc || req_i.rem);
  assign set_src = allow && req_i.loc && !pwon_i && !flag_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (flag_clr_i) flag_q <= 1'b0;
    else if (set_any)    flag_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        src_q <= 1'b0;
    else if (src_clr_i) src_q <= 1'b0;
    else if (set_src)   src_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign src_o  = src_q;
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_detect_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 3125,
  parameter int unsigned BUS_CYC  = 219
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_pin_i,
  input  logic bus_dom_i,
  input  logic lp_mode_i,
  input  logic uv_block_i,
  input  logic flag_clr_i,
  input  logic pwon_i,
  input  logic src_clr_i,
  output logic wake_flag_o,
  output logic wake_src_o,
  output logic bias_up_o
);
  wake_req_t req;

  wake_pin_filter #(.WAKE_CYC(WAKE_CYC)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wake_pin_i),
    .req_o  (req.loc),
    .level_o(bias_up_o)
  );

  wake_bus_filter #(.BUS_CYC(BUS_CYC)) u_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dom_i (bus_dom_i),
    .req_o (req.rem)
  );

  wake_flag_ctrl u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .lp_mode_i (lp_mode_i),
    .uv_block_i(uv_block_i),
    .flag_clr_i(flag_clr_i),
    .pwon_i    (pwon_i),
    .src_clr_i (src_clr_i),
    .flag_o    (wake_flag_o),
    .src_o     (wake_src_o)
  );
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wake_pin_i,
  input logic lp_mode_i,
  input logic uv_block_i,
  input logic flag_clr_i,
  input logic pwon_i,
  input logic src_clr_i,
  input logic wake_flag_o,
  input logic wake_src_o,
  input logic bias_up_o
);
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !wake_flag_o); // R6
  AST_NO_SET_OUTSIDE_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_flag_o && !lp_mode_i) |=> !wake_flag_o); // R4
  AST_NO_SET_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_flag_o && uv_block_i) |=> !wake_flag_o); // R5
  AST_SRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_clr_i |=> !wake_src_o); // R8
  AST_SRC_PWON_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_src_o && pwon_i) |=> !wake_src_o); // R8
  AST_BIAS_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bias_up_o) |-> (bias_up_o == $past(wake_pin_i))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!wake_flag_o && !wake_src_o)); // R10
endmodule

bind wake_detect wake_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wake_pin_i (wake_pin_i),
  .lp_mode_i  (lp_mode_i),
  .uv_block_i (uv_block_i),
  .flag_clr_i (flag_clr_i),
  .pwon_i     (pwon_i),
  .src_clr_i  (src_clr_i),
  .wake_flag_o(wake_flag_o),
  .wake_src_o (wake_src_o),
  .bias_up_o  (bias_up_o)
);

// File: tb/wake_detect_test.sv
`timescale 1ns/1ps
module wake_detect_test;
  localparam int unsigned WAKE_CYC = 8;
  localparam int unsigned BUS_CYC  = 4;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, dom = 1'b0, lp = 1'b1, blk = 1'b0;
  logic clr = 1'b0, pwon = 1'b0, sclr = 1'b0;
  logic flag, src, bias;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_detect #(.WAKE_CYC(WAKE_CYC), .BUS_CYC(BUS_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wake_pin_i(pin), .bus_dom_i(dom),
    .lp_mode_i(lp), .uv_block_i(blk), .flag_clr_i(clr), .pwon_i(pwon),
    .src_clr_i(sclr), .wake_flag_o(flag), .wake_src_o(src), .bias_up_o(bias)
  );

  // [21:18] req, [17] pin [16] dom [15] lp [14] blk [13] clr [12] pwon
  // [11] sclr, [10:3] hold edges, [2] flag [1] src [0] bias expected
  localparam logic [21:0] VEC [NV] = '{
    {4'd10, 7'b0010000, 8'd3, 3'b000}, // R10 idle after reset
    {4'd1,  7'b1010000, 8'd7, 3'b000}, // R1 one edge short
    {4'd1,  7'b1010000, 8'd1, 3'b111}, // R1 R7 rising accepted
    {4'd6,  7'b1010100, 8'd1, 3'b011}, // R6 clear flag
    {4'd8,  7'b1010001, 8'd1, 3'b001}, // R8 clear source
    {4'd2,  7'b0010000, 8'd5, 3'b001}, // R2 partial change
    {4'd2,  7'b1010000, 8'd8, 3'b001}, // R2 reverted, no request
    {4'd1,  7'b0010000, 8'd8, 3'b110}, // R1 falling accepted
    {4'd6,  7'b0010101, 8'd1, 3'b000}, // R6 R8 clear both
    {4'd3,  7'b0110000, 8'd3, 3'b000}, // R3 short dominant
    {4'd3,  7'b0010000, 8'd1, 3'b000}, // R3 gap
    {4'd3,  7'b0110000, 8'd4, 3'b100}, // R3 R7 remote, no source
    {4'd6,  7'b0110100, 8'd1, 3'b000}, // R6 clear while dominant
    {4'd11, 7'b0110000, 8'd6, 3'b000}, // R11 saturated, no re-request
    {4'd4,  7'b1000000, 8'd8, 3'b001}, // R4 R9 not low power, bias follows
    {4'd5,  7'b0011000, 8'd8, 3'b000}, // R5 blocked
    {4'd7,  7'b1010010, 8'd8, 3'b101}, // R7 pwon blocks source
    {4'd6,  7'b0010100, 8'd8, 3'b000}  // R6 clear beats simultaneous set
  };

  task automatic check(input int req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d flag/src/bias actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(2);
    check(10, {flag, src, bias}, 3'b000); // R10 during reset
    rst_n = 1'b1;
    edges(1);
    for (int v = 0; v < NV; v++) begin
      {pin, dom, lp, blk, clr, pwon, sclr} = VEC[v][17:11];
      edges(int'(VEC[v][10:3]));
      check(int'(VEC[v][21:18]), {flag, src, bias}, VEC[v][2:0]);
    end
    // R9 level captured at reset without a request
    {pin, dom, lp, blk, clr, pwon, sclr} = 7'b1010000;
    rst_n = 1'b0;
    edges(1);
    check(10, {flag, src}, 2'b00); // R10
    rst_n = 1'b1;
    edges(2);
    check(9, {flag, src, bias}, 3'b001); // R9 capture
    edges(10);
    check(9, {flag, src, bias}, 3'b001); // R9 no request from capture
    // R11 re-arm after recessive gap
    dom = 1'b1;
    edges(4);
    check(11, {flag, src, bias}, 3'b101);
    clr = 1'b1; edges(1); clr = 1'b0;
    dom = 1'b0; edges(1); dom = 1'b1;
    edges(3);
    check(11, {flag, src, bias}, 3'b001); // R11 one short
    edges(1);
    check(11, {flag, src, bias}, 3'b101); // R11 re-armed
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule